// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a high-speed input clock by a programmable integer ratio. It steers a dual-modulus prescaler that divides by either P or P+1. Two counters drive it. The swallow count (A) sets how many prescaler cycles use the larger modulus. The main count (B) sets how many prescaler cycles make up one output period. One output period therefore spans B·P + A input clocks.

A fractional-N loop can change the ratio on every output period. The block samples the two counts only at the clock edge that closes a period, so a value written in the middle of a period cannot shorten or stretch that period. Pairs that cannot be realised are clamped and flagged for exactly the period that uses them: A above B, or B equal to zero. With B of at least P−1 and A below P, every ratio from P(P−1) upward can be reached.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low, `div_out` is 0, the counts on the inputs are loaded, and `ratio_err` shows whether that pair is out of range. The first period begins with the first clock edge after `rst_n` rises.
- R2: `div_out` pulses once every N input clocks, where N = B·P + A and (A, B) is the pair accepted at the start of that period. With the default P = 8, B = 10 and A = 3 give N = 83.
- R3: `div_out` is high for exactly one input clock per period, in the cycle right after the last clock of the period.
- R4: `mod_ctl` is 1 (larger modulus P+1 selected) for the first A·(P+1) input clocks of a period and 0 for the remaining (B−A)·P clocks. Once it falls, it stays low until the period ends.
- R5: With A = 0, `mod_ctl` stays 0 for the whole period and N = B·P.
- R6: With A = B, `mod_ctl` stays 1 for the whole period and N = B·(P+1).
- R7: `swallow_a` and `main_b` are sampled only on the last clock edge of a period. Changes at any other time have no effect on the current period.
- R8: If A > B, A is clamped to B, and `ratio_err` is 1 for the whole period that uses the clamped pair.
- R9: If B = 0, B is treated as 1 and A is clamped to at most 1, so N = P or P+1. `ratio_err` is 1 for that period.
- R10: `ratio_err` changes only at a period boundary. It returns to 0 when an in-range pair is accepted.
- R11: With P = 8, the pairs B = 7, A = 0..7 followed by B = 8, A = 0 give consecutive ratios 56 through 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| swallow_a | input | 4 | Swallow count A: number of prescaler cycles at modulus P+1 |
| main_b | input | 8 | Main count B: number of prescaler cycles per output period |
| div_out | output | 1 | One-clock pulse per division period |
| mod_ctl | output | 1 | Modulus select: 1 = P+1, 0 = P |
| ratio_err | output | 1 | Pair in use was out of range and has been clamped |

## Verification
All three outputs come from registers. A counts change that arrives before the closing edge of a period shows up in `div_out`, `mod_ctl` and `ratio_err` in the cycle right after that edge. Before that edge it has no visible effect, which is how R7 and R10 are seen at the pins.

A behavioural model in the bench tracks the position inside the current period. At the same edge as the design, it takes the clamped counts from the inputs. It predicts all three outputs for every clock, and the bench compares them at the falling edge.

Separate directed measurements count the clocks between two `div_out` pulses once a new pair has taken effect. They compare that count with B·P + A, as worked out from the requirements.

// File: rtl/psd_pkg.sv
// Package: shared defaults and the modulus-select encoding for the
// pulse-swallow divider. Assumes nothing beyond IEEE 1800-2017.
package psd_pkg;
    localparam int DEF_P  = 8;
    localparam int DEF_AW = 4;
    localparam int DEF_BW = 8;

    // Modulus selected in the prescaler: low -> P, high -> P+1.
    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_SWALL = 1'b1
    } modsel_e;
endpackage

// File: rtl/psd_prescaler.sv
// Module: dual-modulus prescaler model. Counts input clocks and raises
// tc on the last clock of each prescaler cycle. A cycle lasts P clocks when
// sel_hi is low and P+1 clocks when it is high.
// Assumes: sel_hi only changes on a tc edge; P >= 2.
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int P = DEF_P
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_hi,
    output logic tc
);
    localparam int PC_W = $clog2(P + 1);
    localparam logic [PC_W-1:0] LAST_BASE  = PC_W'(P - 1);
    localparam logic [PC_W-1:0] LAST_SWALL = PC_W'(P);

    logic [PC_W-1:0] pc_q;
    modsel_e         mode;

    // Purpose: map the raw select line onto the modulus encoding.
    assign mode = modsel_e'(sel_hi);

    // Purpose: flag the final clock of the current prescaler cycle.
    always_comb begin
        if (mode == MOD_SWALL) tc = (pc_q == LAST_SWALL);
        else                   tc = (pc_q == LAST_BASE);
    end

    // Purpose: count input clocks inside one prescaler cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  pc_q <= '0;
        else if (tc) pc_q <= '0;
        else         pc_q <= pc_q + PC_W'(1);
    end

    // R2: the phase counter never passes the larger terminal value.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= LAST_SWALL);

    // R4: the modulus select from the swallow counter holds inside a cycle.
    p_sel_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(sel_hi));
endmodule

// File: rtl/psd_ratio_gate.sv
// Module: range check and clamp for the programmed pair, plus the error
// flag that belongs to the period in progress.
// Assumes: BW > AW. Clamped values are taken by the counters on the same
// edge that the flag updates (reset or period end).
module psd_ratio_gate
    import psd_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int BW = DEF_BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    input  logic          period_end,
    output logic [AW-1:0] a_ok,
    output logic [BW-1:0] b_ok,
    output logic          err_q
);
    logic [BW-1:0] a_wide;
    logic          b_zero;
    logic          a_over;

    // Purpose: widen A so it can be compared against B.
    assign a_wide = {{(BW-AW){1'b0}}, a_in};

    // Purpose: force B to at least one and A to at most B.
    always_comb begin
        b_zero = (b_in == '0);
        b_ok   = b_zero ? BW'(1) : b_in;
        a_over = (a_wide > b_ok);
        a_ok   = a_over ? b_ok[AW-1:0] : a_in;
    end

    // Purpose: record whether the accepted pair needed clamping.
    always_ff @(posedge clk) begin
        if (!rst_n || period_end) err_q <= b_zero | a_over;
    end

    // R10: the flag only moves at a period boundary.
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(err_q));
endmodule

// File: rtl/psd_swallow_ctr.sv
// Module: swallow (A) and main (B) counters. Advanced by the prescaler
// terminal pulse, they choose the modulus and close each period.
// Assumes: loaded values satisfy 1 <= B and A <= B (ensured by the gate).
module psd_swallow_ctr
    import psd_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int BW = DEF_BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tc,
    input  logic [AW-1:0] a_ld,
    input  logic [BW-1:0] b_ld,
    output logic          sel_hi,
    output logic          period_end,
    output logic          div_q
);
    logic [AW-1:0] a_cnt;
    logic [BW-1:0] b_cnt;

    // Purpose: keep the larger modulus while swallows remain.
    assign sel_hi     = (a_cnt != '0);
    // Purpose: last prescaler cycle of the period is finishing.
    assign period_end = tc && (b_cnt == BW'(1));

    // Purpose: reload at reset or period end, else step on prescaler cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || period_end) begin
            a_cnt <= a_ld;
            b_cnt <= b_ld;
        end else if (tc) begin
            b_cnt <= b_cnt - BW'(1);
            if (a_cnt != '0) a_cnt <= a_cnt - AW'(1);
        end
    end

    // Purpose: register one output pulse per period.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= period_end;
    end

    // R8: the swallow count never exceeds the remaining main count.
    p_a_not_above_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        {{(BW-AW){1'b0}}, a_cnt} <= b_cnt);

    // R9: the main counter never holds zero.
    p_b_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        b_cnt != '0);

    // R3: the output pulse lasts a single clock.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_q |=> !div_q);

    // R4: once swallowing ends it stays ended until the boundary.
    p_swallow_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cnt == '0 && !period_end) |=> (a_cnt == '0));
endmodule

// File: rtl/pulse_swallow_div.sv
// Module: pulse-swallow programmable divider, ratio B*P + A. Connects the
// prescaler model, the ratio gate and the A/B counters.
// Assumes: counts arrive synchronous to clk; the block takes them at the
// last edge of a period (or during reset).
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int P  = DEF_P,
    parameter int AW = DEF_AW,
    parameter int BW = DEF_BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] swallow_a,
    input  logic [BW-1:0] main_b,
    output logic          div_out,
    output logic          mod_ctl,
    output logic          ratio_err
);
    logic          tc;
    logic          sel_hi;
    logic          period_end;
    logic [AW-1:0] a_ok;
    logic [BW-1:0] b_ok;

    psd_prescaler #(.P(P)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_hi (sel_hi),
        .tc     (tc)
    );

    psd_ratio_gate #(.AW(AW), .BW(BW)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_in       (swallow_a),
        .b_in       (main_b),
        .period_end (period_end),
        .a_ok       (a_ok),
        .b_ok       (b_ok),
        .err_q      (ratio_err)
    );

    psd_swallow_ctr #(.AW(AW), .BW(BW)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc         (tc),
        .a_ld       (a_ok),
        .b_ld       (b_ok),
        .sel_hi     (sel_hi),
        .period_end (period_end),
        .div_q      (div_out)
    );

    // Purpose: expose the modulus select to the prescaler pin.
    assign mod_ctl = sel_hi;
endmodule

// File: tb/pulse_swallow_div_tb.sv
module pulse_swallow_div_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 8;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_in = 4'd3;
    logic [7:0] b_in = 8'd10;
    logic       div_out, mod_ctl, ratio_err;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    int  m_a, m_b, m_t;
    bit  m_div, m_err, m_valid = 0;
    int  cyc = 0;

    pulse_swallow_div dut_i (
        .clk(clk), .rst_n(rst_n), .swallow_a(a_in), .main_b(b_in),
        .div_out(div_out), .mod_ctl(mod_ctl), .ratio_err(ratio_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_b(int b);
        return (b == 0) ? 1 : b;
    endfunction
    function automatic int eff_a(int a, int b);
        return (a > eff_b(b)) ? eff_b(b) : a;
    endfunction
    function automatic bit bad_pair(int a, int b);
        return (b == 0) || (a > b);
    endfunction

    task automatic check(bit ok, string what, int got, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got=%0d exp=%0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    // Behavioural model: position in the period and the accepted pair.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_a = eff_a(int'(a_in), int'(b_in));
            m_b = eff_b(int'(b_in));
            m_err = bad_pair(int'(a_in), int'(b_in));
            m_t = 0; m_div = 0; m_valid = 1;
        end else begin
            m_t++;
            m_div = 0;
            if (m_t == m_b * P + m_a) begin
                m_t = 0; m_div = 1;
                m_a = eff_a(int'(a_in), int'(b_in));
                m_b = eff_b(int'(b_in));
                m_err = bad_pair(int'(a_in), int'(b_in));
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (m_valid) begin
            check(div_out == m_div, "div_out", div_out, m_div);
            check(mod_ctl == (m_t < m_a * (P + 1)), "mod_ctl", mod_ctl,
                  int'(m_t < m_a * (P + 1)));
            check(ratio_err == m_err, "ratio_err", ratio_err, m_err);
        end
    end

    // Directed: clocks between two div_out pulses after a pair takes effect.
    task automatic measure(int exp_n);
        int n = 0;
        while (div_out !== 1'b1) @(negedge clk);
        do begin
            @(negedge clk);
            n++;
        end while (div_out !== 1'b1 && n < 5000);
        check(n == exp_n, "period", n, exp_n);
    endtask

    task automatic set_pair(int a, int b);
        @(negedge clk);
        a_in = 4'(a);
        b_in = 8'(b);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: an overlong run counts as one failed check.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed = 12345;
        // R1: reset state
        tag = "R1";
        repeat (4) @(negedge clk);
        check(div_out == 1'b0, "div_out in reset", div_out, 0);
        check(mod_ctl == 1'b1, "mod_ctl in reset", mod_ctl, 1);
        check(ratio_err == 1'b0, "ratio_err in reset", ratio_err, 0);
        rst_n = 1'b1;
        // R2: default pair 3/10 -> 83 clocks
        tag = "R2/R3/R4";
        measure(83);
        measure(83);
        // R5: A = 0
        tag = "R5";
        set_pair(0, 12);
        measure(96);
        // R6: A = B
        tag = "R6";
        set_pair(9, 9);
        measure(81);
        // R8: A above B, clamped, flagged
        tag = "R8";
        set_pair(15, 5);
        measure(45);
        check(ratio_err == 1'b1, "ratio_err after A>B", ratio_err, 1);
        // R9: B = 0 -> B=1, A<=1
        tag = "R9";
        set_pair(2, 0);
        measure(9);
        set_pair(0, 0);
        measure(8);
        check(ratio_err == 1'b1, "ratio_err after B=0", ratio_err, 1);
        // R10: back to an in-range pair clears the flag
        tag = "R10";
        set_pair(1, 6);
        measure(49);
        check(ratio_err == 1'b0, "ratio_err cleared", ratio_err, 0);
        // R11: consecutive ratios from P(P-1)
        tag = "R11";
        for (int a = 0; a < 8; a++) begin
            set_pair(a, 7);
            measure(56 + a);
        end
        set_pair(0, 8);
        measure(64);
        // R7: counts change every few clocks, including bad pairs
        tag = "R7";
        for (int i = 0; i < 1500; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            set_pair((seed >> 8) & 15, (seed >> 14) & 15);
            repeat (2) @(negedge clk);
        end
        set_pair(2, 4);
        measure(34);
        finish_run();
    end
endmodule